// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Selector

This block sits in the execute stage of a five-stage scalar pipeline. For each of the two ALU operands it decides whether the value read from the register file is stale. If it is stale, it substitutes the result of one of the two older instructions still in flight. Each newer instruction's source register numbers travel with it through the decode/execute register. In execute, the block compares them with the destination numbers and register-write enables of the instruction in the execute/memory register and the instruction in the memory/writeback register.

The block is purely combinational. It returns a 2-bit source code per operand and the selected 32-bit operand value in the same cycle as its inputs. The hit detection is done in parallel for every operand and every older stage, and a priority select then picks the youngest matching producer. There is no streaming data interface: every input is a level that the surrounding pipeline registers hold for one cycle, so no handshake or back-pressure applies.

Top module: `operand_bypass`

## Requirements
- R1: When no older stage qualifies for an operand, its source code is 2'b00 and the operand equals the register-file value supplied for it.
- R2: When the execute/memory instruction has its write enable set, has a nonzero destination, and that destination equals the operand's source number, the source code is 2'b10 and the operand equals the execute/memory result.
- R3: When only the memory/writeback instruction meets the same three conditions, the source code is 2'b01 and the operand equals the writeback value.
- R4: When both older stages qualify for the same operand, the execute/memory stage wins: the code is 2'b10 and its result is used.
- R5: A destination of register 0 never causes a forward from either stage, even with the write enable set and a matching source number.
- R6: A stage whose write enable is clear never forwards. If the other stage qualifies, that stage is used; otherwise the register-file value is used.
- R7: Operand A is matched only against source number A and operand B only against source number B, so each gets its own code and value.
- R8: The source code 2'b11 never appears, and both outputs follow their inputs within the same cycle, with no register on the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_src_a_idx | input | 5 | Source register number of operand A of the executing instruction |
| ex_src_b_idx | input | 5 | Source register number of operand B of the executing instruction |
| ex_rf_a_data | input | 32 | Register-file value read for operand A |
| ex_rf_b_data | input | 32 | Register-file value read for operand B |
| mem_wr_en | input | 1 | Execute/memory instruction writes a register |
| mem_dst_idx | input | 5 | Destination register number in the execute/memory stage |
| mem_result | input | 32 | Result held in the execute/memory register |
| wb_wr_en | input | 1 | Memory/writeback instruction writes a register |
| wb_dst_idx | input | 5 | Destination register number in the memory/writeback stage |
| wb_result | input | 32 | Value being written back |
| sel_a | output | 2 | Source code for operand A (00 register file, 01 writeback, 10 execute/memory) |
| sel_b | output | 2 | Source code for operand B, same encoding |
| opnd_a | output | 32 | Selected operand A |
| opnd_b | output | 32 | Selected operand B |

## Verification
Every result of this block is due in the cycle in which its inputs are applied, with zero clock latency. The bench changes the inputs just after a clock edge and samples the codes and operands 1 ns later, well before the next edge. No edge ever lies between stimulus and check, so any registered path would be caught. Register numbers for the random stimulus are drawn from a small range, so double matches, destination-zero matches and matches with a clear enable occur often.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  // Operand source codes; the execute stage decodes these values.
  typedef enum logic [1:0] {
    SRC_RF  = 2'b00,
    SRC_WB  = 2'b01,
    SRC_MEM = 2'b10
  } fwd_src_e;
endpackage

// File: rtl/fwd_match.sv
// Detects whether one older stage holds the newest value of one source register.
module fwd_match #(
  parameter int AW = 5
) (
  input  logic [AW-1:0] src_idx,
  input  logic [AW-1:0] dst_idx,
  input  logic          wr_en,
  output logic          hit
);
  localparam logic [AW-1:0] ZERO_REG = '0;

  logic dst_live;
  assign dst_live = wr_en && (dst_idx != ZERO_REG);
  assign hit      = dst_live && (dst_idx == src_idx);
endmodule

// File: rtl/fwd_select.sv
// Priority pick between the youngest producer, the older producer and the file.
module fwd_select #(
  parameter int DW = 32
) (
  input  logic             hit_young,
  input  logic             hit_old,
  input  logic [DW-1:0]    rf_data,
  input  logic [DW-1:0]    young_data,
  input  logic [DW-1:0]    old_data,
  output fwd_pkg::fwd_src_e sel,
  output logic [DW-1:0]    data
);
  import fwd_pkg::*;

  always_comb begin
    if (hit_young)    sel = SRC_MEM;
    else if (hit_old) sel = SRC_WB;
    else              sel = SRC_RF;
  end

  always_comb begin
    unique case (sel)
      SRC_MEM: data = young_data;
      SRC_WB:  data = old_data;
      default: data = rf_data;
    endcase
  end
endmodule

// File: rtl/operand_bypass.sv
module operand_bypass #(
  parameter int AW = 5,
  parameter int DW = 32
) (
  input  logic [AW-1:0] ex_src_a_idx,
  input  logic [AW-1:0] ex_src_b_idx,
  input  logic [DW-1:0] ex_rf_a_data,
  input  logic [DW-1:0] ex_rf_b_data,
  input  logic          mem_wr_en,
  input  logic [AW-1:0] mem_dst_idx,
  input  logic [DW-1:0] mem_result,
  input  logic          wb_wr_en,
  input  logic [AW-1:0] wb_dst_idx,
  input  logic [DW-1:0] wb_result,
  output logic [1:0]    sel_a,
  output logic [1:0]    sel_b,
  output logic [DW-1:0] opnd_a,
  output logic [DW-1:0] opnd_b
);
  localparam int NUM_OPS = 2;

  logic [NUM_OPS-1:0][AW-1:0] src_idx;
  logic [NUM_OPS-1:0][DW-1:0] rf_data;
  logic [NUM_OPS-1:0][DW-1:0] op_data;
  logic [NUM_OPS-1:0][1:0]    op_sel;

  assign src_idx = {ex_src_b_idx, ex_src_a_idx};
  assign rf_data = {ex_rf_b_data, ex_rf_a_data};

  for (genvar i = 0; i < NUM_OPS; i++) begin : g_op
    logic              hit_mem;
    logic              hit_wb;
    fwd_pkg::fwd_src_e sel_e;

    fwd_match #(.AW(AW)) i_match_mem (
      .src_idx (src_idx[i]),
      .dst_idx (mem_dst_idx),
      .wr_en   (mem_wr_en),
      .hit     (hit_mem)
    );

    fwd_match #(.AW(AW)) i_match_wb (
      .src_idx (src_idx[i]),
      .dst_idx (wb_dst_idx),
      .wr_en   (wb_wr_en),
      .hit     (hit_wb)
    );

    fwd_select #(.DW(DW)) i_select (
      .hit_young  (hit_mem),
      .hit_old    (hit_wb),
      .rf_data    (rf_data[i]),
      .young_data (mem_result),
      .old_data   (wb_result),
      .sel        (sel_e),
      .data       (op_data[i])
    );

    assign op_sel[i] = sel_e;
  end

  assign sel_a  = op_sel[0];
  assign sel_b  = op_sel[1];
  assign opnd_a = op_data[0];
  assign opnd_b = op_data[1];
endmodule

// File: rtl/operand_bypass_chk.sv
module operand_bypass_chk #(
  parameter int AW = 5,
  parameter int DW = 32
) (
  input logic [AW-1:0] ex_src_a_idx,
  input logic [AW-1:0] ex_src_b_idx,
  input logic [DW-1:0] ex_rf_a_data,
  input logic [DW-1:0] ex_rf_b_data,
  input logic          mem_wr_en,
  input logic [AW-1:0] mem_dst_idx,
  input logic [DW-1:0] mem_result,
  input logic          wb_wr_en,
  input logic [AW-1:0] wb_dst_idx,
  input logic [DW-1:0] wb_result,
  input logic [1:0]    sel_a,
  input logic [1:0]    sel_b,
  input logic [DW-1:0] opnd_a,
  input logic [DW-1:0] opnd_b
);
  logic known;
  assign known = !$isunknown({ex_src_a_idx, ex_src_b_idx, mem_wr_en, mem_dst_idx,
                              wb_wr_en, wb_dst_idx, sel_a, sel_b});

  always_comb begin
    if (known) begin
      a_r8_no_code_a: assert (sel_a != 2'b11);
      a_r8_no_code_b: assert (sel_b != 2'b11);
      a_r5_zero_a: assert (ex_src_a_idx != '0 || sel_a == 2'b00);
      a_r5_zero_b: assert (ex_src_b_idx != '0 || sel_b == 2'b00);
      a_r6_no_wen_a: assert (mem_wr_en || wb_wr_en || sel_a == 2'b00);
      a_r6_no_wen_b: assert (mem_wr_en || wb_wr_en || sel_b == 2'b00);
      a_r4_mem_wins_a: assert (!(mem_wr_en && mem_dst_idx != '0 &&
                                 mem_dst_idx == ex_src_a_idx) || sel_a == 2'b10);
      a_r7_b_own_src: assert (!(mem_wr_en && mem_dst_idx != '0 &&
                                mem_dst_idx == ex_src_b_idx) || sel_b == 2'b10);
      a_r2_mem_data_a: assert (sel_a != 2'b10 || opnd_a == mem_result);
      a_r3_wb_data_a:  assert (sel_a != 2'b01 || opnd_a == wb_result);
      a_r1_rf_data_b:  assert (sel_b != 2'b00 || opnd_b == ex_rf_b_data);
    end
  end
endmodule

bind operand_bypass operand_bypass_chk #(.AW(AW), .DW(DW)) i_chk (
  .ex_src_a_idx (ex_src_a_idx),
  .ex_src_b_idx (ex_src_b_idx),
  .ex_rf_a_data (ex_rf_a_data),
  .ex_rf_b_data (ex_rf_b_data),
  .mem_wr_en    (mem_wr_en),
  .mem_dst_idx  (mem_dst_idx),
  .mem_result   (mem_result),
  .wb_wr_en     (wb_wr_en),
  .wb_dst_idx   (wb_dst_idx),
  .wb_result    (wb_result),
  .sel_a        (sel_a),
  .sel_b        (sel_b),
  .opnd_a       (opnd_a),
  .opnd_b       (opnd_b)
);

// File: tb/test_operand_bypass.sv
module test_operand_bypass;
  logic clk = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic [4:0]  ex_src_a_idx, ex_src_b_idx, mem_dst_idx, wb_dst_idx;
  logic [31:0] ex_rf_a_data, ex_rf_b_data, mem_result, wb_result;
  logic        mem_wr_en, wb_wr_en;
  logic [1:0]  sel_a, sel_b;
  logic [31:0] opnd_a, opnd_b;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  operand_bypass i_operand_bypass (
    .ex_src_a_idx (ex_src_a_idx),
    .ex_src_b_idx (ex_src_b_idx),
    .ex_rf_a_data (ex_rf_a_data),
    .ex_rf_b_data (ex_rf_b_data),
    .mem_wr_en    (mem_wr_en),
    .mem_dst_idx  (mem_dst_idx),
    .mem_result   (mem_result),
    .wb_wr_en     (wb_wr_en),
    .wb_dst_idx   (wb_dst_idx),
    .wb_result    (wb_result),
    .sel_a        (sel_a),
    .sel_b        (sel_b),
    .opnd_a       (opnd_a),
    .opnd_b       (opnd_b)
  );

  function automatic logic [1:0] exp_sel(input logic [4:0] src);
    if (mem_wr_en && mem_dst_idx != 5'd0 && mem_dst_idx == src) return 2'b10;
    if (wb_wr_en && wb_dst_idx != 5'd0 && wb_dst_idx == src)    return 2'b01;
    return 2'b00;
  endfunction

  function automatic logic [31:0] exp_data(input logic [1:0] s, input logic [31:0] rf);
    case (s)
      2'b10:   return mem_result;
      2'b01:   return wb_result;
      default: return rf;
    endcase
  endfunction

  task automatic apply(input logic [4:0] sa, input logic [4:0] sb,
                       input logic mw, input logic [4:0] md,
                       input logic ww, input logic [4:0] wd);
    @(posedge clk);
    #1;
    ex_src_a_idx = sa; ex_src_b_idx = sb;
    mem_wr_en = mw; mem_dst_idx = md;
    wb_wr_en = ww; wb_dst_idx = wd;
    ex_rf_a_data = $urandom; ex_rf_b_data = $urandom;
    mem_result = $urandom; wb_result = $urandom;
    #1;  // same cycle, before the next edge
  endtask

  task automatic check_one(input string tag, input logic [1:0] got, input logic [1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", tag, got, exp);
    end
  endtask

  task automatic check_word(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic check_all(input string tag);
    logic [1:0] ea, eb;
    ea = exp_sel(ex_src_a_idx);
    eb = exp_sel(ex_src_b_idx);
    check_one({tag, " sel_a"}, sel_a, ea);
    check_one({tag, " sel_b"}, sel_b, eb);
    check_word({tag, " opnd_a"}, opnd_a, exp_data(ea, ex_rf_a_data));
    check_word({tag, " opnd_b"}, opnd_b, exp_data(eb, ex_rf_b_data));
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    // R1: nothing qualifies
    apply(5'd3, 5'd4, 1'b0, 5'd0, 1'b0, 5'd0);
    check_one("R1 idle sel_a", sel_a, 2'b00);
    check_word("R1 idle opnd_a", opnd_a, ex_rf_a_data);
    // R2: execute/memory forward to A
    apply(5'd7, 5'd9, 1'b1, 5'd7, 1'b0, 5'd7);
    check_one("R2 mem hit sel_a", sel_a, 2'b10);
    check_word("R2 mem hit opnd_a", opnd_a, mem_result);
    // R3: writeback forward to B
    apply(5'd1, 5'd12, 1'b1, 5'd13, 1'b1, 5'd12);
    check_one("R3 wb hit sel_b", sel_b, 2'b01);
    check_word("R3 wb hit opnd_b", opnd_b, wb_result);
    // R4: both stages match
    apply(5'd5, 5'd5, 1'b1, 5'd5, 1'b1, 5'd5);
    check_one("R4 both sel_a", sel_a, 2'b10);
    check_word("R4 both opnd_b", opnd_b, mem_result);
    // R5: destination zero
    apply(5'd0, 5'd0, 1'b1, 5'd0, 1'b1, 5'd0);
    check_one("R5 zero sel_a", sel_a, 2'b00);
    check_word("R5 zero opnd_b", opnd_b, ex_rf_b_data);
    // R6: mem enable clear, wb qualifies
    apply(5'd8, 5'd8, 1'b0, 5'd8, 1'b1, 5'd8);
    check_one("R6 mem off sel_a", sel_a, 2'b01);
    check_word("R6 mem off opnd_a", opnd_a, wb_result);
    // R6: both enables clear
    apply(5'd8, 5'd8, 1'b0, 5'd8, 1'b0, 5'd8);
    check_one("R6 both off sel_b", sel_b, 2'b00);
    // R7: A from mem, B from wb independently
    apply(5'd2, 5'd6, 1'b1, 5'd2, 1'b1, 5'd6);
    check_one("R7 split sel_a", sel_a, 2'b10);
    check_one("R7 split sel_b", sel_b, 2'b01);
    check_word("R7 split opnd_b", opnd_b, wb_result);
    // R8: random mix, result due within the cycle, code 11 never seen
    for (int k = 0; k < 3000; k++) begin
      apply(5'($urandom_range(0, 3)), 5'($urandom_range(0, 3)),
            1'($urandom), 5'($urandom_range(0, 3)),
            1'($urandom), 5'($urandom_range(0, 3)));
      check_all("R8 random");
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (50000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule